// File: doc/BRIEF.md
# Share-Weighted Multi-Master Bus Arbiter

This block decides which of several bus masters may drive a shared bus. Each master has a dedicated request line, a dedicated grant line and a completion strobe. A master raises its request and waits for its grant. While it holds the grant it pulses its completion strobe once for every transfer it finishes. The completion strobe also tells the arbiter that the master has finished with the bus for that transfer, and it is the only event that can make the grant move.

Each master has a programmed integer weight. The arbiter keeps a credit counter for each master and loads it from that weight. When several masters contend, the requester with the largest weight keeps the bus until its credits are spent. Ownership then passes to the requester with the next smaller weight, and so on down to the smallest weight. Once every requester has spent its credits, all counters reload and a new round starts. A master that requests without pause therefore gets a share of transfers equal to its weight divided by the sum of the weights of the contending masters.

The controller is a two-state machine.
- `ST_IDLE` means no grant is asserted. The transition *claim* moves it to `ST_BUSY` when any request is seen. *Claim* reloads every counter and picks the heaviest requester.
- In `ST_BUSY` three transitions can follow a completion strobe from the owner. They are tried in the order below, and the first one that applies is taken.
  - *Continue* stays in `ST_BUSY`. It applies when some requester still has credit. The heaviest such requester becomes the owner, which may be the current owner again.
  - *Renew* stays in `ST_BUSY`. It applies when requests remain but none has credit. All counters reload and the heaviest requester becomes the owner.
  - *Release* returns to `ST_IDLE`. It applies when no request remains, and it reloads every counter.

Top module: `share_burst_arbiter`

## Requirements
- R1: After reset `gnt_o` is 0. While no request is pending and no grant is held, `gnt_o` remains 0. After the owner's last completion strobe, with no requests left, `gnt_o` returns to 0 in the next cycle.
- R2: From the idle state, the grant rises in the cycle after a request is sampled. It goes to the requester with the largest weight.
- R3: At most one bit of `gnt_o` is 1 in any cycle.
- R4: While the owner's completion strobe is low, `gnt_o` does not change. A change happens only in the cycle after the owner pulses its completion strobe.
- R5: Within a round, ownership moves from the largest weight to the smallest. Among equal weights, the lower master index (bit position in `req_i`) goes first.
- R6: During contention each owner keeps the grant for exactly as many completed transfers as its weight.
- R7: A weight of 0 behaves exactly like a weight of 1.
- R8: A master that is the only requester keeps the grant from one transfer to the next with no gap, whatever its weight.
- R9: When all masters request continuously, over whole rounds each master's transfer count equals its weight.
- R10: A completion strobe from a master that does not hold the grant has no effect on the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MASTERS | Request line per master, bit i belongs to master i |
| fin_i | input | N_MASTERS | Completion strobe per master; one pulse for each completed transfer, which also ends that transfer's use of the bus |
| share_cfg_i | input | N_MASTERS*SHARE_W | Weights; master i uses bits [i*SHARE_W +: SHARE_W] |
| gnt_o | output | N_MASTERS | Grant line per master, registered, at most one bit set |

## Verification
Two things can happen in the same cycle. The owner can spend its last credit while another master still has credit left, and the owner can strobe completion while dropping its request. In that cycle the decrement and the choice of the next owner have to agree. The bench provokes this by letting every master request at once with different weights, including a tie and a zero weight. Each master drops its request on the strobe of its final transfer. The scoreboard compares the exact owner of every completed transfer with a sequence worked out by hand from the weights. It also checks that each master's transfer count matches its weight and that the grant falls to zero after the last strobe.

// File: rtl/sba_pkg.sv
package sba_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } sba_state_e;
endpackage

// File: rtl/sba_share_pick.sv
// Picks the candidate with the largest weight; lower index wins on a tie.
module sba_share_pick #(
    parameter int N  = 4,
    parameter int W  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]   cand,
    input  logic [N*W-1:0] weight,
    output logic [IW-1:0]  idx,
    output logic           valid
);
    logic [W-1:0] best_w;

    always_comb begin
        best_w = '0;
        idx    = '0;
        valid  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!valid || (weight[i*W +: W] > best_w))) begin
                best_w = weight[i*W +: W];
                idx    = IW'(i);
                valid  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sba_credit_bank.sv
// One credit counter per master; reload from effective weight, decrement on owner transfer.
module sba_credit_bank #(
    parameter int N  = 4,
    parameter int W  = 4,
    parameter int IW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reload,
    input  logic           dec_en,
    input  logic [IW-1:0]  dec_idx,
    input  logic [N*W-1:0] cfg,
    output logic [N*W-1:0] eff,
    output logic [N-1:0]   live_nz
);
    for (genvar g = 0; g < N; g++) begin : g_cnt
        logic [W-1:0] eff_w;
        logic [W-1:0] credit_q;
        logic [W-1:0] credit_after;
        logic         hit;

        assign eff_w = (cfg[g*W +: W] == '0) ? W'(1) : cfg[g*W +: W];
        assign eff[g*W +: W] = eff_w;
        assign hit = dec_en && (dec_idx == IW'(g));
        assign credit_after = (hit && (credit_q != '0)) ? (credit_q - W'(1)) : credit_q;
        assign live_nz[g] = (credit_after != '0);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                credit_q <= '0;
            end else if (reload) begin
                credit_q <= eff_w;
            end else begin
                credit_q <= credit_after;
            end
        end
    end
endmodule

// File: rtl/sba_ctrl_fsm.sv
// Ownership state machine: claim, continue, renew, release.
module sba_ctrl_fsm
    import sba_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  fin,
    input  logic          cand_valid,
    input  logic [IW-1:0] cand_idx,
    input  logic          fresh_valid,
    input  logic [IW-1:0] fresh_idx,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] owner,
    output logic          reload,
    output logic          dec_en
);
    sba_state_e    state_q, state_d;
    logic [IW-1:0] owner_q, owner_d;
    logic          owner_fin;

    assign owner_fin = fin[owner_q];

    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        reload  = 1'b0;
        dec_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (|req) begin
                    reload  = 1'b1;
                    owner_d = fresh_idx;
                    state_d = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (owner_fin) begin
                    dec_en = 1'b1;
                    if (cand_valid) begin
                        owner_d = cand_idx;
                    end else if (fresh_valid) begin
                        reload  = 1'b1;
                        owner_d = fresh_idx;
                    end else begin
                        reload  = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    always_comb begin
        gnt   = '0;
        owner = owner_q;
        if (state_q == ST_BUSY) begin
            gnt[owner_q] = 1'b1;
        end
    end
endmodule

// File: rtl/share_burst_arbiter.sv
module share_burst_arbiter #(
    parameter int N_MASTERS = 4,
    parameter int SHARE_W   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_MASTERS-1:0]         req_i,
    input  logic [N_MASTERS-1:0]         fin_i,
    input  logic [N_MASTERS*SHARE_W-1:0] share_cfg_i,
    output logic [N_MASTERS-1:0]         gnt_o
);
    localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;

    logic [N_MASTERS*SHARE_W-1:0] eff_w;
    logic [N_MASTERS-1:0]         live_nz;
    logic [N_MASTERS-1:0]         cand;
    logic                         cand_valid, fresh_valid;
    logic [IW-1:0]                cand_idx, fresh_idx, owner;
    logic                         reload, dec_en;

    assign cand = req_i & live_nz;

    sba_credit_bank #(.N(N_MASTERS), .W(SHARE_W), .IW(IW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (reload),
        .dec_en  (dec_en),
        .dec_idx (owner),
        .cfg     (share_cfg_i),
        .eff     (eff_w),
        .live_nz (live_nz)
    );

    sba_share_pick #(.N(N_MASTERS), .W(SHARE_W), .IW(IW)) u_pick_cand (
        .cand   (cand),
        .weight (eff_w),
        .idx    (cand_idx),
        .valid  (cand_valid)
    );

    sba_share_pick #(.N(N_MASTERS), .W(SHARE_W), .IW(IW)) u_pick_fresh (
        .cand   (req_i),
        .weight (eff_w),
        .idx    (fresh_idx),
        .valid  (fresh_valid)
    );

    sba_ctrl_fsm #(.N(N_MASTERS), .IW(IW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req_i),
        .fin         (fin_i),
        .cand_valid  (cand_valid),
        .cand_idx    (cand_idx),
        .fresh_valid (fresh_valid),
        .fresh_idx   (fresh_idx),
        .gnt         (gnt_o),
        .owner       (owner),
        .reload      (reload),
        .dec_en      (dec_en)
    );
endmodule

// File: rtl/sba_checker.sv
module sba_checker #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req,
    input logic [N-1:0] fin,
    input logic [N-1:0] gnt
);
    // R3: never two grants
    a_r3_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R4 and R10: grant frozen unless the owner itself strobes completion
    a_r4_hold_until_fin: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt != '0) && ((gnt & fin) == '0)) |=> $stable(gnt));

    // R1: no request, no grant stays no grant
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt == '0) && (req == '0)) |=> (gnt == '0));

    // R2: idle request claims the bus one cycle later
    a_r2_claim_next: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt == '0) && (req != '0)) |=> (gnt != '0));

    // R8: the only requester, holding the bus, keeps it
    a_r8_lone_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt != '0) && (req == gnt)) |=> (gnt == $past(gnt)));
endmodule

bind share_burst_arbiter sba_checker #(.N(N_MASTERS)) u_sba_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_i),
    .fin   (fin_i),
    .gnt   (gnt_o)
);

// File: tb/share_burst_arbiter_tb_top.sv
`timescale 1ns/1ps
module share_burst_arbiter_tb_top;
    localparam int N = 4;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] fin = '0;
    logic [N*W-1:0] cfg = 16'h0213; // weights m0=3 m1=1 m2=2 m3=0
    logic [N-1:0] gnt;

    int chk_total = 0;
    int chk_fail  = 0;
    int cycles    = 0;
    int jobs  [N];
    int stall [N];
    int xcnt  [N];
    logic spur0 = 1'b0;
    int exp_q [$];

    always #2 clk = ~clk; // 250 MHz

    share_burst_arbiter #(.N_MASTERS(N), .SHARE_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .fin_i(fin),
        .share_cfg_i(cfg), .gnt_o(gnt)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        chk_total++;
        if (!ok) begin
            chk_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // One cycle: drive masters at the falling edge, then monitor the scoreboard.
    task automatic tick();
        @(negedge clk);
        cycles++;
        for (int i = 0; i < N; i++) begin
            fin[i] = 1'b0;
            if (gnt[i] && jobs[i] > 0) begin
                if (stall[i] > 0) stall[i]--;
                else begin
                    fin[i] = 1'b1;
                    jobs[i]--;
                end
            end
            req[i] = (jobs[i] > 0);
        end
        if (spur0 && !gnt[0]) fin[0] = 1'b1;
        #1;
        if ((gnt & fin) != '0) begin
            int who = 0;
            for (int i = 0; i < N; i++) if (gnt[i] && fin[i]) who = i;
            xcnt[who]++;
            if (exp_q.size() == 0) check(1'b0, "R5 unexpected transfer", who, -1);
            else begin
                int e = exp_q.pop_front();
                check(who == e, "R5/R6 transfer owner", who, e);
            end
        end
    endtask

    task automatic push_seq(input int s[]);
        foreach (s[k]) exp_q.push_back(s[k]);
    endtask

    task automatic wait_idle(input string rq);
        bit done = 1'b0;
        for (int c = 0; c < 300 && !done; c++) begin
            tick();
            if (jobs[0] == 0 && jobs[1] == 0 && jobs[2] == 0 && jobs[3] == 0 && gnt == '0) done = 1'b1;
        end
        check(done, rq, int'(gnt), 0);
    endtask

    initial begin
        #100000;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", chk_total + 1, chk_fail + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin jobs[i] = 0; stall[i] = 0; xcnt[i] = 0; end
        tick(); tick();
        #1 rst_n = 1'b1;
        tick();
        check(gnt == '0, "R1 reset grant", int'(gnt), 0);
        tick();
        check(gnt == '0, "R1 idle without request", int'(gnt), 0);

        // Lone requester m2, five transfers: claim latency and continuous hold (R2, R8)
        push_seq('{2, 2, 2, 2, 2});
        jobs[2] = 5;
        tick(); // request driven
        tick(); // grant visible
        check(gnt == 4'b0100, "R2 claim one cycle after request", int'(gnt), 4);
        for (int k = 0; k < 4; k++) begin
            tick();
            check(gnt == 4'b0100, "R8 lone requester keeps grant", int'(gnt), 4);
        end
        tick();
        check(gnt == '0, "R1 grant drops after last transfer", int'(gnt), 0);

        // All masters contend: two full rounds (R5, R6, R7, R9)
        for (int i = 0; i < N; i++) xcnt[i] = 0;
        push_seq('{0, 0, 0, 2, 2, 1, 3, 0, 0, 0, 2, 2, 1, 3});
        jobs[0] = 6; jobs[1] = 2; jobs[2] = 4; jobs[3] = 2;
        wait_idle("R9 contention run completes");
        check(xcnt[0] == 6, "R9 share of m0", xcnt[0], 6);
        check(xcnt[1] == 2, "R9 share of m1", xcnt[1], 2);
        check(xcnt[2] == 4, "R9 share of m2", xcnt[2], 4);
        check(xcnt[3] == 2, "R7 zero weight served as one", xcnt[3], 2);

        // Stalled owner, another master waits, stray strobe from non-owner (R4, R10)
        push_seq('{1, 0, 0, 0});
        jobs[1] = 1; stall[1] = 4;
        begin
            bit seen = 1'b0;
            for (int c = 0; c < 10 && !seen; c++) begin
                tick();
                if (gnt[1]) seen = 1'b1;
            end
            check(seen, "R2 m1 claims bus", int'(gnt), 2);
        end
        jobs[0] = 3; spur0 = 1'b1;
        tick();
        check(gnt == 4'b0010, "R10 stray strobe ignored", int'(gnt), 2);
        spur0 = 1'b0;
        for (int k = 0; k < 3; k++) begin
            tick();
            check(gnt == 4'b0010, "R4 grant held while owner stalls", int'(gnt), 2);
        end
        tick();
        check(gnt == 4'b0001, "R4 grant moves after owner strobe", int'(gnt), 1);
        wait_idle("R1 stall run completes");

        // Tie between m1 (1) and m3 (0 -> 1): alternation, lower index first (R5, R7)
        push_seq('{1, 3, 1, 3});
        jobs[1] = 2; jobs[3] = 2;
        wait_idle("R7 tie run completes");

        check(exp_q.size() == 0, "R6 all expected transfers seen", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", chk_total, chk_fail);
        $finish;
    end
endmodule